// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous request channel and a 32K x 8 asynchronous static RAM. Each request is a single byte, read or written, offered with a valid/ready handshake. The block turns it into pin activity whose timing is measured in system clock cycles: address, active-low chip select, write strobe and output enable, plus an 8-bit data path. The data path is split into an outgoing byte, an incoming byte and a drive enable for the tri-state pad.

Every analog minimum (cycle times, strobe width, data setup, access delays, bus release time and power-up wait) is a nanosecond parameter. Each is converted at elaboration into a clock count, rounded up, using a clock period given in picoseconds. When the power-good input is low, the part is kept deselected with outputs off so that it can retain its contents. After power-good rises, a fixed wake-up wait runs before the first access. Between requests the RAM stays deselected, which is its low-power state.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `ram_cs_n`, `ram_we_n` and `ram_oe_n` are 1, and `ram_dq_oe` and `rsp_valid` are 0.
- R2: While `pwr_good` is low, `req_ready` is 0 and no chip select falling edge starts. Once the current access ends, `ram_cs_n` and `ram_oe_n` stay at 1 and `ram_dq_oe` stays at 0.
- R3: After `pwr_good` rises, chip select does not fall before floor(T_WAKE/period)+1 clock cycles have passed, which is 10 cycles at the defaults.
- R4: A read drives chip select low, the write strobe high and output enable low. During a write, output enable stays high. The write strobe is only ever low while chip select is low.
- R5: During a read, chip select stays low for at least ceil(T_RC/period) cycles. The returned byte is the one the RAM presents after at least ceil(T_AA/period) cycles of stable address with chip select and output enable low.
- R6: For a read accepted at clock edge 0, `rsp_valid` is high for exactly one cycle, starting at edge max(cAA, cRC-1, cOE)+1 with counts in cycles. That is edge 9 at the defaults.
- R7: The write strobe falls at least one cycle after chip select falls. It stays low for at least ceil(T_WP/period) cycles. The address is stable and the data byte is driven for at least ceil(T_DS/period) cycles before the strobe rises.
- R8: A write is ended by the write strobe rising while chip select is still low. Address, data and drive enable are unchanged at that edge. Chip select stays low for at least ceil(T_WC/period) cycles in total.
- R9: `ram_dq_oe` is never high while the RAM may drive the bus (chip select low, strobe high, output enable low). It first rises at least ceil(T_HZ/period) cycles after that condition ends.
- R10: `req_ready` is high only when no access is in progress and power is good. A read returns the byte most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | High when the RAM supply is valid |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| ram_addr | output | 15 | RAM address pins |
| ram_cs_n | output | 1 | Chip select, active low |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_dq_out | output | 8 | Byte to drive onto the data pins |
| ram_dq_oe | output | 1 | Drive enable for the data pins |
| ram_dq_in | input | 8 | Byte read from the data pins |

## Verification
Pin changes follow one clock edge after the accepting edge. The read response is due exactly max(cAA, cRC-1, cOE)+2 falling edges after the falling edge where `req_valid` and `req_ready` were seen together. The bench counts falling edges and flags a pulse that is early, late or missing. A bench RAM model updates its outputs on falling edges. It returns a corrupted byte until the access count has run, so a response sampled too early carries wrong data. Strobe widths, setup, hold, cycle lengths, release gaps and the wake-up wait are measured in whole cycles from the first falling edge after each pin change.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_RETAIN, ST_WAKE, ST_IDLE, ST_RD, ST_WSET, ST_WPUL, ST_WEND, ST_TURN
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_OFF = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    // minimum time -> cycles, rounded up
    function automatic int ns_ceil(input int ns, input int clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    // strictly-greater-than wait -> cycles
    function automatic int ns_above(input int ns, input int clk_ps);
        return (ns * 1000) / clk_ps + 1;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sramc_rdcap.sv
`timescale 1ns/1ps
module sramc_rdcap #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic [DW-1:0] din,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= cap_en;
            if (cap_en) rdata <= din;
        end
    end
endmodule

// File: rtl/sramc_seq.sv
`timescale 1ns/1ps
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int AW        = 15,
    parameter int DW        = 8,
    parameter int CNT_W     = 4,
    parameter int RD_LAST   = 8,
    parameter int WP_LAST   = 5,
    parameter int WEND_LAST = 0,
    parameter int TURN_LAST = 2,
    parameter int WAKE_LAST = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_good,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          cap_en,
    output pin_ctl_t      ctl,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] dout_q
);
    seq_state_e       state;
    logic [CNT_W-1:0] cnt;

    assign req_ready = (state == ST_IDLE) && pwr_good;
    assign cap_en    = (state == ST_RD) && (cnt == CNT_W'(RD_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_RETAIN;
            cnt    <= '0;
            ctl    <= PINS_OFF;
            addr_q <= '0;
            dout_q <= '0;
        end else begin
            unique case (state)
                ST_RETAIN: begin
                    ctl <= PINS_OFF;
                    if (pwr_good) begin
                        state <= ST_WAKE;
                        cnt   <= '0;
                    end
                end
                ST_WAKE: begin
                    if (!pwr_good) state <= ST_RETAIN;
                    else if (cnt == CNT_W'(WAKE_LAST)) state <= ST_IDLE;
                    else cnt <= cnt + 1'b1;
                end
                ST_IDLE: begin
                    if (!pwr_good) begin
                        state <= ST_RETAIN;
                    end else if (req_valid) begin
                        addr_q   <= req_addr;
                        cnt      <= '0;
                        ctl.cs_n <= 1'b0;
                        if (req_write) begin
                            dout_q    <= req_wdata;
                            ctl.dq_oe <= 1'b1;
                            state     <= ST_WSET;
                        end else begin
                            ctl.oe_n <= 1'b0;
                            state    <= ST_RD;
                        end
                    end
                end
                ST_RD: begin
                    if (cnt == CNT_W'(RD_LAST)) begin
                        ctl.cs_n <= 1'b1;
                        ctl.oe_n <= 1'b1;
                        cnt      <= '0;
                        state    <= ST_TURN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WSET: begin
                    ctl.we_n <= 1'b0;
                    cnt      <= '0;
                    state    <= ST_WPUL;
                end
                ST_WPUL: begin
                    if (cnt == CNT_W'(WP_LAST)) begin
                        ctl.we_n <= 1'b1;
                        cnt      <= '0;
                        state    <= ST_WEND;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WEND: begin
                    if (cnt == CNT_W'(WEND_LAST)) begin
                        ctl.cs_n  <= 1'b1;
                        ctl.dq_oe <= 1'b0;
                        state     <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TURN: begin
                    if (cnt == CNT_W'(TURN_LAST)) state <= ST_IDLE;
                    else cnt <= cnt + 1'b1;
                end
                default: state <= ST_RETAIN;
            endcase
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sramc_pkg::*;
#(
    parameter int CLK_PS    = 5000,
    parameter int T_RC_NS   = 40,
    parameter int T_AA_NS   = 40,
    parameter int T_OE_NS   = 20,
    parameter int T_HZ_NS   = 15,
    parameter int T_WC_NS   = 40,
    parameter int T_WP_NS   = 30,
    parameter int T_AW_NS   = 30,
    parameter int T_DS_NS   = 22,
    parameter int T_WAKE_NS = 45
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_good,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);
    localparam int C_RC   = ns_ceil(T_RC_NS, CLK_PS);
    localparam int C_AA   = ns_ceil(T_AA_NS, CLK_PS);
    localparam int C_OE   = ns_ceil(T_OE_NS, CLK_PS);
    localparam int C_HZ   = ns_ceil(T_HZ_NS, CLK_PS);
    localparam int C_WC   = ns_ceil(T_WC_NS, CLK_PS);
    localparam int C_WP   = ns_ceil(T_WP_NS, CLK_PS);
    localparam int C_AW   = ns_ceil(T_AW_NS, CLK_PS);
    localparam int C_DS   = ns_ceil(T_DS_NS, CLK_PS);
    localparam int C_WAKE = ns_above(T_WAKE_NS, CLK_PS);

    localparam int RD_LAST   = imax(C_AA, imax(C_RC - 1, C_OE));
    localparam int WP_CYC    = imax(1, imax(C_WP, imax(C_DS, C_AW - 1)));
    localparam int WP_LAST   = WP_CYC - 1;
    localparam int WEND_LAST = imax(1, C_WC - 1 - WP_CYC) - 1;
    localparam int TURN_LAST = imax(1, C_HZ) - 1;
    localparam int WAKE_LAST = imax(1, C_WAKE) - 1;
    localparam int CNT_MAX   = imax(imax(RD_LAST, WP_LAST), imax(WEND_LAST, imax(TURN_LAST, WAKE_LAST)));
    localparam int CNT_W     = $clog2(CNT_MAX + 2);

    pin_ctl_t ctl;
    logic     cap_en;

    sramc_seq #(
        .AW(ADDR_W), .DW(DATA_W), .CNT_W(CNT_W),
        .RD_LAST(RD_LAST), .WP_LAST(WP_LAST), .WEND_LAST(WEND_LAST),
        .TURN_LAST(TURN_LAST), .WAKE_LAST(WAKE_LAST)
    ) u_seq (
        .clk(clk), .rst(rst), .pwr_good(pwr_good),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .cap_en(cap_en), .ctl(ctl),
        .addr_q(ram_addr), .dout_q(ram_dq_out)
    );

    sramc_rdcap #(.DW(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .cap_en(cap_en), .din(ram_dq_in),
        .rvalid(rsp_valid), .rdata(rsp_rdata)
    );

    assign ram_cs_n  = ctl.cs_n;
    assign ram_we_n  = ctl.we_n;
    assign ram_oe_n  = ctl.oe_n;
    assign ram_dq_oe = ctl.dq_oe;
endmodule

// File: rtl/sramc_chk.sv
`timescale 1ns/1ps
module sramc_chk
    import sramc_pkg::*;
#(
    parameter int CLK_PS  = 5000,
    parameter int T_RC_NS = 40,
    parameter int T_AA_NS = 40,
    parameter int T_WP_NS = 30,
    parameter int T_DS_NS = 22,
    parameter int T_WC_NS = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_good,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_cs_n,
    input logic              ram_we_n,
    input logic              ram_oe_n,
    input logic [DATA_W-1:0] ram_dq_out,
    input logic              ram_dq_oe
);
    initial begin
        a_r5_counts_positive: assert (CLK_PS > 0
            && (T_RC_NS == 0 || ns_ceil(T_RC_NS, CLK_PS) >= 1)
            && (T_AA_NS == 0 || ns_ceil(T_AA_NS, CLK_PS) >= 1)
            && (T_WP_NS == 0 || ns_ceil(T_WP_NS, CLK_PS) >= 1)
            && (T_DS_NS == 0 || ns_ceil(T_DS_NS, CLK_PS) >= 1)
            && (T_WC_NS == 0 || ns_ceil(T_WC_NS, CLK_PS) >= 1))
            else $error("timing count below one cycle");
    end

    a_r2_ready_needs_power: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |-> !req_ready);
    a_r2_no_start_unpowered: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_cs_n) |-> $past(pwr_good));
    a_r4_we_inside_cs: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> !ram_cs_n);
    a_r4_write_oe_high: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> ram_oe_n);
    a_r7_we_after_cs: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_we_n) |-> $past(!ram_cs_n));
    a_r8_hold_on_we_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we_n) |-> (!ram_cs_n && ram_dq_oe && $stable(ram_addr) && $stable(ram_dq_out)));
    a_r9_no_drive_with_oe: assert property (@(posedge clk) disable iff (rst)
        ram_dq_oe |-> ram_oe_n);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    a_r10_idle_deselected: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ram_cs_n && ram_we_n));
endmodule

bind sram_async_ctrl sramc_chk #(
    .CLK_PS(CLK_PS), .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS),
    .T_WP_NS(T_WP_NS), .T_DS_NS(T_DS_NS), .T_WC_NS(T_WC_NS)
) u_chk (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .ram_addr(ram_addr), .ram_cs_n(ram_cs_n),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
    localparam int CLK_PS = 5000;
    localparam int RC_B   = (40 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int AA_B   = (40 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int OE_B   = (20 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int HZ_B   = (15 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int WC_B   = (40 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int WP_B   = (30 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int DS_B   = (22 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int WAKE_B = (45 * 1000) / CLK_PS + 1;
    localparam int RD_B   = (AA_B > RC_B - 1) ? ((AA_B > OE_B) ? AA_B : OE_B)
                                               : ((RC_B - 1 > OE_B) ? RC_B - 1 : OE_B);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_good = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [14:0] ram_addr;
    logic        ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe;
    logic [7:0]  ram_dq_out;
    logic [7:0]  ram_dq_in = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    sram_async_ctrl dut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
        .ram_dq_in(ram_dq_in)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural RAM and scoreboard
    logic [7:0]  mem [int];
    logic [7:0]  sb  [int];
    int          n_neg = 0;
    bit          p_cs_n = 1, p_we_n = 1, p_drv = 0, p_act = 0, p_dq_oe = 0, p_pg = 0;
    logic [14:0] p_addr = '0, win_addr = '0;
    logic [7:0]  p_dout = '0;
    int rd_age = 0, off_age = 1000, wake_age = 0, cs_len = 0, we_len = 0;
    int ds_age = 0, p_ds_age = 0, rd_due = 0;
    bit cs_wr = 0, rd_pend = 0;
    logic [7:0] rd_exp = '0;

    always @(negedge clk) begin
        bit drv, act;
        logic [7:0] v;
        n_neg++;
        if (rst) begin
            p_cs_n = 1; p_we_n = 1; p_drv = 0; p_act = 0; p_dq_oe = 0; p_pg = 0;
            wake_age = 0; off_age = 1000; rd_pend = 0;
        end else begin
            drv = !ram_cs_n && ram_we_n && !ram_oe_n;
            act = !ram_cs_n && !ram_we_n;
            // read data model (R5): corrupted until access time has elapsed
            if (drv) rd_age = (p_drv && ram_addr == p_addr) ? rd_age + 1 : 1;
            else rd_age = 0;
            v = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00;
            ram_dq_in = (drv && rd_age >= AA_B - 1) ? v : ~v;
            // bus release (R9)
            if (drv) off_age = 0;
            else if (off_age < 1000) off_age++;
            if (ram_dq_oe && drv) chk(0, "R9 contention", 1, 0);
            if (ram_dq_oe && !p_dq_oe) chk(off_age >= HZ_B + 1, "R9 release gap", off_age, HZ_B + 1);
            // power (R2, R3)
            if (pwr_good) begin if (wake_age < 100000) wake_age++; end
            else wake_age = 0;
            if (!ram_cs_n && p_cs_n) begin
                chk(p_pg, "R2 start while unpowered", 0, 1);
                chk(wake_age >= WAKE_B, "R3 wake wait", wake_age, WAKE_B);
                if (!ram_oe_n) chk(ram_we_n, "R4 read mode", ram_we_n, 1);
                cs_len = 0; cs_wr = 0;
            end
            if (!ram_cs_n) cs_len++;
            if (!ram_we_n) begin
                cs_wr = 1;
                if (p_we_n) begin
                    chk(!ram_cs_n && !p_cs_n, "R7 strobe after select", p_cs_n, 0);
                    chk(ram_oe_n, "R4 write with output enable high", ram_oe_n, 1);
                end
            end
            if (ram_cs_n && !p_cs_n) begin
                if (cs_wr) chk(cs_len >= WC_B, "R8 write cycle length", cs_len, WC_B);
                else chk(cs_len >= RC_B, "R5 read cycle length", cs_len, RC_B);
            end
            // write window (R7, R8)
            if (act && !p_act) begin
                win_addr = ram_addr; we_len = 1;
            end else if (act) begin
                we_len++;
                if (ram_addr != win_addr) chk(0, "R7 address moved", ram_addr, win_addr);
            end
            if (!act && p_act) begin
                chk(we_len >= WP_B, "R7 strobe width", we_len, WP_B);
                chk(p_ds_age >= DS_B, "R7 data setup", p_ds_age, DS_B);
                chk(!ram_cs_n, "R8 strobe ends write", ram_cs_n, 0);
                chk(ram_dq_oe && ram_dq_out == p_dout && ram_addr == win_addr,
                    "R8 hold at strobe rise", ram_dq_out, p_dout);
                mem[int'(win_addr)] = p_dout;
            end
            if (ram_dq_oe) ds_age = (p_dq_oe && ram_dq_out == p_dout) ? ds_age + 1 : 1;
            else ds_age = 0;
            // response (R6, R10)
            if (rsp_valid) begin
                chk(rd_pend && n_neg == rd_due, "R6 response edge", n_neg, rd_due);
                chk(rsp_rdata == rd_exp, "R10 read-back", rsp_rdata, rd_exp);
                rd_pend = 0;
            end else if (rd_pend && n_neg == rd_due) begin
                chk(0, "R6 response missing", 0, 1);
                rd_pend = 0;
            end
            if (req_valid && req_ready) begin
                chk(!rd_pend && ram_cs_n, "R10 one access at a time", ram_cs_n, 1);
                if (req_write) sb[int'(req_addr)] = req_wdata;
                else begin
                    rd_pend = 1;
                    rd_due = n_neg + RD_B + 2;
                    rd_exp = sb.exists(int'(req_addr)) ? sb[int'(req_addr)] : 8'h00;
                end
            end
            p_cs_n = ram_cs_n; p_we_n = ram_we_n; p_drv = drv; p_act = act;
            p_dq_oe = ram_dq_oe; p_addr = ram_addr; p_dout = ram_dq_out;
            p_ds_age = ds_age; p_pg = pwr_good;
        end
    end

    task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    logic [14:0] alist [16];

    initial begin
        logic [15:0] lfsr;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe && !rsp_valid,
            "R1 reset pins", {ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid}, 5'b11100);
        @(posedge clk); #1; rst = 0;
        @(negedge clk);
        chk(ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe && !rsp_valid,
            "R1 after reset", {ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid}, 5'b11100);
        // R2: request held while unpowered is not taken
        @(posedge clk); #1;
        req_valid = 1; req_write = 1; req_addr = 15'h0000; req_wdata = 8'h3C;
        repeat (20) @(negedge clk);
        chk(!req_ready && ram_cs_n && ram_oe_n, "R2 retention hold", req_ready, 0);
        @(posedge clk); #1; pwr_good = 1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1; req_valid = 0;
        // directed accesses: corners of the address space, read/write mixes
        issue(1, 15'h7FFF, 8'hA5);
        issue(1, 15'h1234, 8'h00);
        issue(1, 15'h4321, 8'hFF);
        issue(0, 15'h0000, 8'h00);
        issue(0, 15'h7FFF, 8'h00);
        issue(0, 15'h1234, 8'h00);
        issue(1, 15'h1234, 8'h5A);       // read followed by write (R9)
        issue(0, 15'h1234, 8'h00);       // overwrite read-back (R10)
        issue(0, 15'h4321, 8'h00);
        // power drop while idle, then wake (R2, R3)
        repeat (20) @(negedge clk);
        @(posedge clk); #1; pwr_good = 0;
        repeat (15) @(negedge clk);
        chk(ram_cs_n && ram_oe_n && !ram_dq_oe && !req_ready, "R2 retention pins",
            {ram_cs_n, ram_oe_n, ram_dq_oe, req_ready}, 4'b1100);
        @(posedge clk); #1; pwr_good = 1;
        issue(0, 15'h7FFF, 8'h00);
        // pseudo-random traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 16; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            alist[i] = lfsr[14:0];
            issue(1, alist[i], lfsr[7:0] ^ 8'h96);
        end
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(lfsr[0], alist[lfsr[4:1]], lfsr[15:8]);
        end
        repeat (30) @(negedge clk);
        chk(!rd_pend, "R6 no response outstanding", rd_pend, 0);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end
endmodule